// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate Unit

This execution unit takes one 32-bit instruction word for a dual signed multiply-accumulate operation and the values of its three source registers. It splits two of those values into halfwords and forms two exact signed 16x16 products. It adds both products to a 32-bit accumulate value and returns the low 32 bits of the sum, together with the destination register index and a write enable. The word can be laid out in either of two encodings. A mode input picks the narrow-prefix form or the conditional form. One bit in the word swaps the halfwords of the second multiplier operand before the multiplies.

The decoded source indices are driven out so that the surrounding datapath can fetch the operand values. The result path is purely combinational. The only state is a sticky saturation flag. An accumulation that leaves the signed 32-bit range, on a word that is written back, sets this flag. Only a separate clear input lowers it. The result wraps and is never saturated.

Top module: `dsmac_unit`

## Requirements
- R1: With `form_sel`=0 the word must have bits [31:20]=12'hFB2 and bits [7:5]=3'b000. The fields are then: first operand index at [19:16], accumulate index at [15:12], destination index at [11:8], exchange bit at [4] and second operand index at [3:0].
- R2: With `form_sel`=1 the word must have bits [27:20]=8'h70, bits [7:6]=2'b00 and bit [4]=1. The fields are then: destination index at [19:16], accumulate index at [15:12], second operand index at [11:8], exchange bit at [5] and first operand index at [3:0]. Bits [31:28] are the condition field and are not decoded.
- R3: With the exchange bit at 0, `result` is the low 32 bits of acc + n[31:16]*m[31:16] + n[15:0]*m[15:0], with every term signed.
- R4: With the exchange bit at 1, `result` is the low 32 bits of acc + n[31:16]*m[15:0] + n[15:0]*m[31:16], with every term signed.
- R5: `acc_ovf` is 1 exactly when the mathematically exact sum lies outside [-2^31, 2^31-1]. An intermediate wrap neither hides nor fakes an overflow.
- R6: If any fixed bit of the selected form does not match, `illegal` is 1 and `wr_en` is 0, and `q_flag` is not set by that word.
- R7: In the conditional form `wr_en` follows `cond_pass`. In the narrow form `cond_pass` has no effect and `wr_en` is 1 for a matching word.
- R8: When `wr_en` and `acc_ovf` are both 1 at a rising clock edge, `q_flag` is 1 from that edge on. It stays 1 until it is cleared.
- R9: `q_clear` at a clock edge drives `q_flag` to 0 at that edge. If a set occurs at the same edge, the set wins.
- R10: While `rst_n` is 0 at a clock edge, `q_flag` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Synchronous active-low reset |
| form_sel | input | 1 | 0: narrow-prefix form, 1: conditional form |
| insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition-check result from outside (conditional form only) |
| op_n | input | 32 | First multiplier operand value |
| op_m | input | 32 | Second multiplier operand value |
| op_acc | input | 32 | Accumulate operand value |
| q_clear | input | 1 | Clears the sticky flag |
| rn_idx | output | 4 | Decoded first operand index |
| rm_idx | output | 4 | Decoded second operand index |
| ra_idx | output | 4 | Decoded accumulate index |
| rd_idx | output | 4 | Decoded destination index |
| result | output | 32 | Wrapped 32-bit sum |
| acc_ovf | output | 1 | Exact sum overflowed 32 signed bits |
| wr_en | output | 1 | Result is to be written back |
| illegal | output | 1 | Fixed opcode bits do not match |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `q_clear`, `form_sel` and `insn` are stable and free of X at each rising edge. They also take the sticky flag as a function only of the write-back qualifier, the overflow flag and the clear input. The bench changes inputs only on falling edges and holds them across the following rising edge. It drives every input to a known value from the first cycle of reset on. Operand values are chosen so that a wrap of the intermediate sum occurs only where a check expects it.

// File: rtl/dsmac_pkg.sv
// Package: shared widths and the decoded-field record of the dual
// multiply-accumulate unit. Assumes a 32-bit word and 16 registers.
package dsmac_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;

    typedef enum logic {
        FORM_NARROW = 1'b0,
        FORM_COND   = 1'b1
    } form_e;

    typedef struct packed {
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rd;
        logic             xchg;
        logic             match;
    } dec_t;
endpackage

// File: rtl/dsmac_decode.sv
// Decoder: pulls the register fields and the exchange bit out of the
// instruction word for the selected form. It also flags whether the fixed
// opcode bits match. Assumes a 32-bit instruction word.
module dsmac_decode
    import dsmac_pkg::*;
(
    input  form_e             form,
    input  logic [WORD_W-1:0] insn,
    output dec_t              dec
);
    localparam logic [11:0] NARROW_OP = 12'hFB2;
    localparam logic [7:0]  COND_OP   = 8'h70;

    // Field extraction and fixed-bit comparison for each form.
    always_comb begin
        dec = '0;
        if (form == FORM_NARROW) begin
            dec.rn    = insn[19:16];
            dec.ra    = insn[15:12];
            dec.rd    = insn[11:8];
            dec.xchg  = insn[4];
            dec.rm    = insn[3:0];
            dec.match = (insn[31:20] == NARROW_OP) && (insn[7:5] == 3'b000);
        end else begin
            dec.rd    = insn[19:16];
            dec.ra    = insn[15:12];
            dec.rm    = insn[11:8];
            dec.xchg  = insn[5];
            dec.rn    = insn[3:0];
            dec.match = (insn[27:20] == COND_OP) && (insn[7:6] == 2'b00)
                        && insn[4];
        end
    end
endmodule

// File: rtl/dsmac_datapath.sv
// Datapath: two exact signed halfword products, optionally with the second
// operand's halfwords swapped, summed with the accumulate value. The sum is
// formed at two extra bits so that overflow is judged on the exact total.
// Assumes DATA_W is even.
module dsmac_datapath #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_n,
    input  logic [DATA_W-1:0] op_m,
    input  logic [DATA_W-1:0] op_a,
    input  logic              xchg,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;
    localparam int SUM_W  = DATA_W + 2;

    logic [DATA_W-1:0]       m_sel;
    logic signed [DATA_W-1:0] prod [LANES];
    logic signed [SUM_W-1:0]  exact;
    logic [2:0]               top_bits;

    // Halfword exchange of the second operand.
    always_comb begin
        m_sel = xchg ? {op_m[HALF_W-1:0], op_m[DATA_W-1:HALF_W]} : op_m;
    end

    // One exact signed product per halfword lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] a_h;
        logic signed [HALF_W-1:0] b_h;
        assign a_h = op_n[g*HALF_W +: HALF_W];
        assign b_h = m_sel[g*HALF_W +: HALF_W];
        assign prod[g] = DATA_W'(a_h) * DATA_W'(b_h);
    end

    // Exact wide sum, wrapped low part, and range check of the top bits.
    always_comb begin
        exact = $signed({{2{op_a[DATA_W-1]}}, op_a})
              + $signed({{2{prod[0][DATA_W-1]}}, prod[0]})
              + $signed({{2{prod[1][DATA_W-1]}}, prod[1]});
        sum      = exact[DATA_W-1:0];
        top_bits = exact[SUM_W-1:DATA_W-1];
        ovf      = !((&top_bits) || (~|top_bits));
    end
endmodule

// File: rtl/dsmac_sticky.sv
// Sticky flag: set by a qualified overflow, cleared only by an explicit
// clear. A set wins over a clear in the same cycle. Synchronous active-low
// reset.
module dsmac_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_req));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !flag);
endmodule

// File: rtl/dsmac_unit.sv
// Top: dual signed halfword multiply-accumulate execution unit. It decodes
// the word, computes the wrapped sum combinationally and qualifies write-back
// by the opcode match and, in the conditional form, by cond_pass. The sticky
// flag is set only by written-back overflows. Register fetch is external.
module dsmac_unit
    import dsmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              form_sel,
    input  logic [WORD_W-1:0] insn,
    input  logic              cond_pass,
    input  logic [WORD_W-1:0] op_n,
    input  logic [WORD_W-1:0] op_m,
    input  logic [WORD_W-1:0] op_acc,
    input  logic              q_clear,
    output logic [IDX_W-1:0]  rn_idx,
    output logic [IDX_W-1:0]  rm_idx,
    output logic [IDX_W-1:0]  ra_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] result,
    output logic              acc_ovf,
    output logic              wr_en,
    output logic              illegal,
    output logic              q_flag
);
    form_e form;
    dec_t  dec;
    logic  q_set;

    assign form = form_e'(form_sel);

    dsmac_decode u_dec (
        .form (form),
        .insn (insn),
        .dec  (dec)
    );

    dsmac_datapath #(.DATA_W(WORD_W)) u_dp (
        .op_n (op_n),
        .op_m (op_m),
        .op_a (op_acc),
        .xchg (dec.xchg),
        .sum  (result),
        .ovf  (acc_ovf)
    );

    // Write-back qualification and outputs of the decoded fields.
    always_comb begin
        wr_en   = dec.match && ((form == FORM_NARROW) || cond_pass);
        illegal = !dec.match;
        q_set   = wr_en && acc_ovf;
        rn_idx  = dec.rn;
        rm_idx  = dec.rm;
        ra_idx  = dec.ra;
        rd_idx  = dec.rd;
    end

    dsmac_sticky u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (q_set),
        .clr_req (q_clear),
        .flag    (q_flag)
    );

    p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);
    p_illegal_no_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !q_flag) |=> !q_flag);
    p_cond_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (form_sel && !cond_pass) |-> !wr_en);
    p_zero_mult_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_m == '0) |-> (!acc_ovf && result == op_acc));
endmodule

// File: tb/tb_dsmac_unit.sv
// Bench for dsmac_unit: a vector table walked by one loop, then directed
// tests for reset and for the flag's clear and set priority.
module tb_dsmac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        form_sel = 1'b0;
    logic [31:0] insn = '0;
    logic        cond_pass = 1'b0;
    logic [31:0] op_n = '0, op_m = '0, op_acc = '0;
    logic        q_clear = 1'b0;
    logic [3:0]  rn_idx, rm_idx, ra_idx, rd_idx;
    logic [31:0] result;
    logic        acc_ovf, wr_en, illegal, q_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dsmac_unit dut (
        .clk(clk), .rst_n(rst_n), .form_sel(form_sel), .insn(insn),
        .cond_pass(cond_pass), .op_n(op_n), .op_m(op_m), .op_acc(op_acc),
        .q_clear(q_clear), .rn_idx(rn_idx), .rm_idx(rm_idx), .ra_idx(ra_idx),
        .rd_idx(rd_idx), .result(result), .acc_ovf(acc_ovf), .wr_en(wr_en),
        .illegal(illegal), .q_flag(q_flag)
    );

    // Vector: {form, xchg, cond_pass, corrupt, op_n, op_m, op_acc}
    localparam int NV = 10;
    localparam logic [99:0] VEC [NV] = '{
        {4'b0010, 32'h00030004, 32'h00050006, 32'h00000010},
        {4'b0110, 32'h00030004, 32'h00050006, 32'h00000010},
        {4'b1010, 32'hFFFF0002, 32'h00070003, 32'h00000000},
        {4'b1100, 32'h00030004, 32'h00050006, 32'h00000010},
        {4'b0010, 32'h80008000, 32'h80008000, 32'h00000000},
        {4'b1010, 32'h000A000A, 32'h000AFFF6, 32'h7FFFFFF0},
        {4'b0011, 32'h80008000, 32'h80008000, 32'h7FFFFFFF},
        {4'b1110, 32'h7FFF8000, 32'h7FFF7FFF, 32'h80000000},
        {4'b1011, 32'h00030004, 32'h00050006, 32'h00000010},
        {4'b0100, 32'h00010000, 32'h00000001, 32'h7FFFFFFF}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model written from R3, R4 and R5.
    task automatic model(input logic [31:0] n, input logic [31:0] m,
                         input logic [31:0] a, input logic x,
                         output logic [31:0] res, output logic of);
        logic [31:0] ms;
        longint s;
        ms = x ? {m[15:0], m[31:16]} : m;
        s = longint'($signed(a))
          + longint'($signed(n[31:16])) * longint'($signed(ms[31:16]))
          + longint'($signed(n[15:0])) * longint'($signed(ms[15:0]));
        res = s[31:0];
        of  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endtask

    initial begin : watchdog
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic q_exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "q_flag after reset", {31'b0, q_flag}, 32'd0);
        rst_n = 1'b1;
        q_exp = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rn, rm, ra, rd;
            logic        fm, xb, cp, bad, exp_wr, exp_of;
            logic [31:0] exp_res;
            {fm, xb, cp, bad} = VEC[i][99:96];
            rd = 4'(i);
            rn = 4'(i + 1);
            rm = 4'(i + 3);
            ra = 4'(i + 7);
            @(negedge clk);
            form_sel  = fm;
            cond_pass = cp;
            op_n      = VEC[i][95:64];
            op_m      = VEC[i][63:32];
            op_acc    = VEC[i][31:0];
            if (!fm) insn = {12'hFB2, rn, ra, rd, 3'b000, xb, rm};
            else     insn = {4'hE, 8'h70, rd, ra, rm, 2'b00, xb, 1'b1, rn};
            if (bad) insn[24] = ~insn[24];
            #2;
            model(op_n, op_m, op_acc, xb, exp_res, exp_of);
            exp_wr = !bad && (!fm || cp);
            if (!fm) begin
                check("R1", "rd_idx", {28'b0, rd_idx}, {28'b0, rd});
                check("R1", "rn_idx", {28'b0, rn_idx}, {28'b0, rn});
                check("R1", "rm_idx", {28'b0, rm_idx}, {28'b0, rm});
                check("R1", "ra_idx", {28'b0, ra_idx}, {28'b0, ra});
            end else begin
                check("R2", "rd_idx", {28'b0, rd_idx}, {28'b0, rd});
                check("R2", "rn_idx", {28'b0, rn_idx}, {28'b0, rn});
                check("R2", "rm_idx", {28'b0, rm_idx}, {28'b0, rm});
                check("R2", "ra_idx", {28'b0, ra_idx}, {28'b0, ra});
            end
            if (xb) check("R4", "result exchanged", result, exp_res);
            else    check("R3", "result straight", result, exp_res);
            check("R5", "acc_ovf", {31'b0, acc_ovf}, {31'b0, exp_of});
            check("R6", "illegal", {31'b0, illegal}, {31'b0, bad});
            check("R7", "wr_en", {31'b0, wr_en}, {31'b0, exp_wr});
            q_exp = q_exp | (exp_wr & exp_of);
            @(negedge clk);
            check(bad ? "R6" : "R8", "q_flag", {31'b0, q_flag}, {31'b0, q_exp});
        end

        // R9: clear with no set.
        @(negedge clk);
        op_m = 32'h0;
        op_acc = 32'h0;
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
        check("R9", "q_flag after clear", {31'b0, q_flag}, 32'd0);

        // R6: an illegal word with overflowing operands leaves the flag at 0.
        form_sel = 1'b0;
        insn = 32'hFB300000;
        op_n = 32'h80008000;
        op_m = 32'h80008000;
        op_acc = 32'h7FFFFFFF;
        @(negedge clk);
        check("R6", "q_flag after illegal word", {31'b0, q_flag}, 32'd0);

        // R8: a set with a valid overflowing word, then R9: set beats clear.
        insn = 32'hFB200000;
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
        check("R9", "set wins over clear", {31'b0, q_flag}, 32'd1);
        op_m = 32'h0;
        repeat (2) @(negedge clk);
        check("R8", "q_flag holds", {31'b0, q_flag}, 32'd1);

        // R10: reset lowers the set flag.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "q_flag under reset", {31'b0, q_flag}, 32'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule